// File: doc/BRIEF.md
# Head-of-Queue Frame Action Controller

This block sits at the read side of a shared cell FIFO that carries frames from many virtual connections (VCs). Each cycle it looks at the cell at the FIFO head. That cell carries a VC index, a flag marking the first cell of a frame, and a priority bit (1 = low priority, also called tagged). The block decides whether the cell is transmitted as it is, transmitted after promotion to high priority, or thrown away. It settles this once, on the first cell of each frame, and stores the choice per VC. Later cells of the same frame reuse that stored choice, even when frames from different VCs are interleaved in the queue.

Two per-VC credit banks live inside the block. The penalty bank counts frames that the fairness logic upstream has ordered dropped. The make-up bank counts untagged frames that admission lost and that should be made up by promoting a later tagged frame. Upstream logic raises a one-cycle increment strobe with a VC index for either bank. A tagged frame reaching the head consumes a penalty credit first, and a make-up credit only if no penalty credit is pending. Every cell that leaves the FIFO, whether sent or dropped, raises a release pulse with its VC. The buffer accounting uses that pulse to return one cell of space and to lower that VC's occupancy.

Top module: `frame_head_ctrl`

## Requirements
- R1: After reset all credit counters are zero and every VC's stored action is "send". With no head cell, neither `tx_valid` nor `hd_pop` is asserted, and a tagged first cell is sent unchanged.
- R2: A first cell with `hd_low`=1 whose VC has a nonzero penalty count is dropped. In that cycle `hd_pop`=1 and `tx_valid`=0. The penalty count of that VC drops by one.
- R3: A first cell with `hd_low`=1 whose VC has a zero penalty count and a nonzero make-up count is promoted. It is sent with `tx_low`=0, and the make-up count drops by one.
- R4: When both counts of a VC are nonzero, a tagged first cell is dropped and only the penalty count is consumed. The make-up credit remains for a later tagged frame.
- R5: A first cell with `hd_low`=0 is always sent unchanged and consumes no credit. No cell is ever sent with a lower priority than it arrived with.
- R6: A cell with `hd_first`=0 repeats the action stored for its VC by that VC's most recent popped first cell: 0 = send, 1 = promote, 2 = drop. Each VC keeps its own stored action.
- R7: A cell being sent is popped only in a cycle where `tx_ready`=1. While `tx_ready`=0 the cell stays presented, and a first cell held this way consumes its credit once, on the cycle it is popped.
- R8: Every popped cell, whether sent or dropped, raises `free_pulse` for one cycle with `free_vc` equal to the cell's VC. Nothing else raises it.
- R9: Each credit counter saturates at 2^CNT_W-1. If an increment and a consumption hit the same counter in the same cycle, the count does not change.
- R10: With `hd_valid`=0 the block pops nothing, sends nothing and frees nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pen_inc | input | 1 | Add one penalty (drop) credit |
| pen_vc | input | VC_W | VC for pen_inc |
| loss_inc | input | 1 | Add one make-up (promote) credit |
| loss_vc | input | VC_W | VC for loss_inc |
| hd_valid | input | 1 | FIFO head holds a cell |
| hd_vc | input | VC_W | VC of head cell |
| hd_first | input | 1 | Head cell starts a frame |
| hd_low | input | 1 | Head cell priority, 1 = low (tagged) |
| hd_pop | output | 1 | Remove head cell this cycle |
| tx_valid | output | 1 | Cell offered to the link |
| tx_ready | input | 1 | Link accepts the offered cell |
| tx_vc | output | VC_W | VC of offered cell |
| tx_low | output | 1 | Priority of offered cell after promotion |
| free_pulse | output | 1 | One cell left the FIFO |
| free_vc | output | VC_W | VC of the cell that left |

## Verification
The bench stalls a first cell whose frame will be promoted and then checks that the next tagged frame on that VC is sent plainly. A design that consumed a credit on every stalled cycle would drain the make-up count early and fail this check. It loads both credit kinds on one VC and checks drop-then-promote order, so a reversed priority would show up as a promoted frame where a dropped one is expected. It sends untagged continuation cells of a dropped frame, which a design that decided per cell instead of per frame would wrongly send. It pushes a counter past its limit and lands an increment on the same cycle as a consumption, so a counter that wraps or double-counts shows up as a wrong number of dropped frames.

// File: rtl/fhc_pkg.sv
package fhc_pkg;
    typedef enum logic [1:0] {
        ACT_SEND  = 2'd0,
        ACT_RETAG = 2'd1,
        ACT_DROP  = 2'd2
    } act_e;
endpackage

// File: rtl/vc_credit_bank.sv
// Per-VC saturating credit counters with one increment and one consume port.
module vc_credit_bank #(
    parameter int NUM_VC = 8,
    parameter int CNT_W  = 4,
    localparam int VC_W  = $clog2(NUM_VC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc,
    input  logic [VC_W-1:0]   inc_vc,
    input  logic              dec,
    input  logic [VC_W-1:0]   dec_vc,
    output logic [NUM_VC-1:0] nz
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [NUM_VC-1:0][CNT_W-1:0] cnt;
    } bank_s;

    bank_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_VC; i++) begin
            logic up, dn;
            up = inc && (inc_vc == VC_W'(i));
            dn = dec && (dec_vc == VC_W'(i)) && (st_q.cnt[i] != '0);
            if (up && !dn && st_q.cnt[i] != CNT_MAX)
                st_d.cnt[i] = st_q.cnt[i] + 1'b1;
            else if (dn && !up)
                st_d.cnt[i] = st_q.cnt[i] - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < NUM_VC; g++) begin : g_nz
        assign nz[g] = (st_q.cnt[g] != '0);
    end
endmodule

// File: rtl/head_action_sel.sv
// Picks the action for the head cell: fresh decision on a first cell,
// stored per-VC action otherwise.
module head_action_sel (
    input  logic             hd_first,
    input  logic             hd_low,
    input  logic             pen_nz,
    input  logic             loss_nz,
    input  fhc_pkg::act_e    stored,
    output fhc_pkg::act_e    act
);
    always_comb begin
        if (!hd_first)              act = stored;
        else if (hd_low && pen_nz)  act = fhc_pkg::ACT_DROP;
        else if (hd_low && loss_nz) act = fhc_pkg::ACT_RETAG;
        else                        act = fhc_pkg::ACT_SEND;
    end
endmodule

// File: rtl/frame_head_ctrl.sv
module frame_head_ctrl #(
    parameter int NUM_VC = 8,
    parameter int CNT_W  = 4,
    localparam int VC_W  = $clog2(NUM_VC)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pen_inc,
    input  logic [VC_W-1:0] pen_vc,
    input  logic            loss_inc,
    input  logic [VC_W-1:0] loss_vc,
    input  logic            hd_valid,
    input  logic [VC_W-1:0] hd_vc,
    input  logic            hd_first,
    input  logic            hd_low,
    output logic            hd_pop,
    output logic            tx_valid,
    input  logic            tx_ready,
    output logic [VC_W-1:0] tx_vc,
    output logic            tx_low,
    output logic            free_pulse,
    output logic [VC_W-1:0] free_vc
);
    import fhc_pkg::*;

    typedef struct packed {
        act_e [NUM_VC-1:0] flag;
    } flag_s;

    flag_s st_d, st_q;

    logic [NUM_VC-1:0] pen_nz, loss_nz;
    act_e act;
    logic pop, take_first, pen_dec, loss_dec;

    vc_credit_bank #(.NUM_VC(NUM_VC), .CNT_W(CNT_W)) u_pen (
        .clk(clk), .rst_n(rst_n),
        .inc(pen_inc), .inc_vc(pen_vc),
        .dec(pen_dec), .dec_vc(hd_vc),
        .nz(pen_nz)
    );

    vc_credit_bank #(.NUM_VC(NUM_VC), .CNT_W(CNT_W)) u_loss (
        .clk(clk), .rst_n(rst_n),
        .inc(loss_inc), .inc_vc(loss_vc),
        .dec(loss_dec), .dec_vc(hd_vc),
        .nz(loss_nz)
    );

    head_action_sel u_sel (
        .hd_first(hd_first),
        .hd_low(hd_low),
        .pen_nz(pen_nz[hd_vc]),
        .loss_nz(loss_nz[hd_vc]),
        .stored(st_q.flag[hd_vc]),
        .act(act)
    );

    always_comb begin
        tx_valid   = hd_valid && (act != ACT_DROP);
        tx_low     = (act == ACT_RETAG) ? 1'b0 : hd_low;
        tx_vc      = hd_vc;
        pop        = hd_valid && ((act == ACT_DROP) || tx_ready);
        take_first = pop && hd_first;
        pen_dec    = take_first && (act == ACT_DROP);
        loss_dec   = take_first && (act == ACT_RETAG);
        st_d = st_q;
        if (take_first) st_d.flag[hd_vc] = act;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hd_pop     = pop;
    assign free_pulse = pop;
    assign free_vc    = hd_vc;
endmodule

// File: rtl/fhc_checker.sv
module fhc_checker #(
    parameter int VC_W = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            hd_valid,
    input logic            hd_first,
    input logic            hd_low,
    input logic            hd_pop,
    input logic            tx_valid,
    input logic            tx_ready,
    input logic            tx_low,
    input logic            free_pulse,
    input logic [VC_W-1:0] free_vc,
    input logic [VC_W-1:0] hd_vc
);
    a_r7_pop_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |-> !hd_pop);

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !hd_valid |-> (!hd_pop && !tx_valid && !free_pulse));

    a_r2_drop_only_tagged_first: assert property (@(posedge clk) disable iff (!rst_n)
        (hd_pop && !tx_valid && hd_first) |-> hd_low);

    a_r5_never_demote: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !hd_low) |-> !tx_low);

    a_r8_free_vc_matches: assert property (@(posedge clk) disable iff (!rst_n)
        free_pulse |-> (free_vc == hd_vc && hd_valid));
endmodule

bind frame_head_ctrl fhc_checker #(.VC_W(VC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .hd_valid(hd_valid), .hd_first(hd_first),
    .hd_low(hd_low), .hd_pop(hd_pop), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_low(tx_low), .free_pulse(free_pulse), .free_vc(free_vc), .hd_vc(hd_vc)
);

// File: tb/frame_head_ctrl_tb.sv
module frame_head_ctrl_tb;
    localparam int NUM_VC = 8;
    localparam int CNT_W  = 4;
    localparam int VC_W   = $clog2(NUM_VC);
    localparam int CMAX   = (1 << CNT_W) - 1;

    logic clk = 0, rst_n = 0;
    logic pen_inc = 0, loss_inc = 0, hd_valid = 0, hd_first = 0, hd_low = 0, tx_ready = 0;
    logic [VC_W-1:0] pen_vc = 0, loss_vc = 0, hd_vc = 0;
    logic hd_pop, tx_valid, tx_low, free_pulse;
    logic [VC_W-1:0] tx_vc, free_vc;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    int mv[NUM_VC], mu[NUM_VC], mf[NUM_VC];

    always #4 clk = ~clk;

    frame_head_ctrl #(.NUM_VC(NUM_VC), .CNT_W(CNT_W)) u_dut (.*);

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #1600000;
        n_bad++;
        $display("FAIL watchdog: run hung, expected completion");
        finish_run();
    end

    // expected action: 0 send, 1 promote, 2 drop
    function automatic int exp_act(bit f, bit lo, int vc);
        if (!f) return mf[vc];
        if (lo && mv[vc] > 0) return 2;
        if (lo && mu[vc] > 0) return 1;
        return 0;
    endfunction

    function automatic int sat_upd(int c, bit up, bit dn);
        if (dn && c == 0) dn = 0;
        if (up && !dn && c < CMAX) return c + 1;
        if (dn && !up) return c - 1;
        return c;
    endfunction

    task automatic step(bit v, int vc, bit f, bit lo, bit rdy,
                        bit pi, int pvc, bit li, int lvc, string tag);
        int a;
        bit e_tv, e_low, e_pop;
        string t;
        @(negedge clk);
        hd_valid = v; hd_vc = VC_W'(vc); hd_first = f; hd_low = lo; tx_ready = rdy;
        pen_inc = pi; pen_vc = VC_W'(pvc); loss_inc = li; loss_vc = VC_W'(lvc);
        #1;
        a = v ? exp_act(f, lo, vc) : 0;
        e_tv  = v && a != 2;
        e_low = (a == 1) ? 1'b0 : lo;
        e_pop = v && (a == 2 || rdy);
        t = tag;
        if (t == "") begin
            if (!v) t = "R10";
            else if (a == 2) t = "R2";
            else if (f && a == 1) t = "R3";
            else if (!rdy) t = "R7";
            else if (f) t = "R5";
            else t = "R6";
        end
        n_chk++;
        if (tx_valid !== e_tv || hd_pop !== e_pop || free_pulse !== e_pop ||
            (e_tv && (tx_low !== e_low || tx_vc !== VC_W'(vc))) ||
            (e_pop && free_vc !== VC_W'(vc))) begin
            n_bad++;
            $display("FAIL %s (free pulse R8): act tv=%b low=%b pop=%b free=%b fvc=%0d exp tv=%b low=%b pop=%b free=%b fvc=%0d",
                     t, tx_valid, tx_low, hd_pop, free_pulse, free_vc,
                     e_tv, e_low, e_pop, e_pop, vc);
        end
        // model update for the coming edge
        for (int i = 0; i < NUM_VC; i++) begin
            bit tf;
            tf = e_pop && f && vc == i;
            mv[i] = sat_upd(mv[i], pi && pvc == i, tf && a == 2);
            mu[i] = sat_upd(mu[i], li && lvc == i, tf && a == 1);
            if (tf) mf[i] = a;
        end
    endtask

    task automatic idle(string tag); step(0, 0, 0, 0, 1, 0, 0, 0, 0, tag); endtask

    initial begin
        for (int i = 0; i < NUM_VC; i++) begin mv[i] = 0; mu[i] = 0; mf[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        // R1: reset state
        idle("R1");
        step(1, 2, 1, 1, 1, 0, 0, 0, 0, "R1");
        step(1, 2, 0, 1, 1, 0, 0, 0, 0, "R1");
        // R4: both credits on VC 3, drop wins, promote follows
        step(0, 0, 0, 0, 1, 1, 3, 1, 3, "R4");
        step(1, 3, 1, 1, 1, 0, 0, 0, 0, "R4");
        step(1, 3, 0, 0, 1, 0, 0, 0, 0, "R6");
        step(1, 3, 1, 1, 1, 0, 0, 0, 0, "R4");
        step(1, 3, 0, 1, 1, 0, 0, 0, 0, "R6");
        step(1, 3, 1, 1, 1, 0, 0, 0, 0, "R4");
        // R7: stalled promoted first cell consumes one credit
        step(0, 0, 0, 0, 1, 0, 0, 1, 5, "R7");
        for (int k = 0; k < 3; k++) step(1, 5, 1, 1, 0, 0, 0, 0, 0, "R7");
        step(1, 5, 1, 1, 1, 0, 0, 0, 0, "R7");
        step(1, 5, 1, 1, 1, 0, 0, 0, 0, "R7");
        // R9: saturation
        for (int k = 0; k < 20; k++) step(0, 0, 0, 0, 1, 1, 1, 0, 0, "R9");
        for (int k = 0; k < CMAX + 1; k++) step(1, 1, 1, 1, 1, 0, 0, 0, 0, "R9");
        // R9: simultaneous increment and consume
        step(0, 0, 0, 0, 1, 1, 6, 0, 0, "R9");
        step(1, 6, 1, 1, 1, 1, 6, 0, 0, "R9");
        step(1, 6, 1, 1, 1, 0, 0, 0, 0, "R9");
        step(1, 6, 1, 1, 1, 0, 0, 0, 0, "R9");
        // random mix, interleaved VCs
        for (int k = 0; k < 4000; k++) begin
            bit v, f, lo, rdy, pi, li;
            int vc, pvc, lvc;
            v   = ($urandom % 10) < 8;
            vc  = $urandom % NUM_VC;
            f   = ($urandom % 10) < 3;
            lo  = $urandom % 2;
            rdy = ($urandom % 10) < 7;
            pi  = ($urandom % 100) < 15;
            li  = ($urandom % 100) < 15;
            pvc = $urandom % NUM_VC;
            lvc = $urandom % NUM_VC;
            step(v, vc, f, lo, rdy, pi, pvc, li, lvc, "");
        end
        finish_run();
    end

    initial void'($urandom(32'd1234));
endmodule